// File: doc/BRIEF.md
# Age-Prioritized Deflection Router Allocator

This block decides, once per cycle, where every flit present at a bufferless mesh router goes. Up to four flits arrive on the north, east, south and west links, and one more may be offered by the local source. Each flit carries its full destination (X, Y) and an age value. No flit is ever held in the router. Every link flit leaves through some output in the same allocation. Flits are ranked oldest first and then served one at a time. Each flit takes a free output that brings it closer to its destination. If none is free, it is deflected onto any remaining link output.

Two routing modes are selectable per cycle. In multidimensional mode a flit asks for every direction that shortens its remaining X or Y distance. In dimension-ordered mode it asks only for the X direction while X differs, and for the Y direction after that. A flit already at its destination asks for the local ejection port. The local injection flit is admitted only when enough outputs remain to guarantee a complete matching. Otherwise the local source sees backpressure. Results are registered, so grants appear one clock after the flits are presented.

Top module: `deflect_alloc`

## Requirements
- R1: Every valid link flit receives exactly one grant (its grant valid bit set) one clock after it is presented.
- R2: No two flits are granted the same output port in the same cycle.
- R3: A flit with a larger age value is older and is served first. A younger flit whose only productive output was taken is deflected.
- R4: Equal ages are resolved by index: link 0 (N), 1 (E), 2 (S), 3 (W), then the injection flit at index 4. The lower index is served first.
- R5: In multidimensional mode (modeDor=0), a flit requests every productive port and takes the lowest-coded free one. Port codes are N=0 (y+1), E=1 (x+1), S=2 (y-1), W=3 (x-1), Local=4. Port fields are 3 bits per flit, flit 0 in the lowest bits.
- R6: In dimension-ordered mode (modeDor=1), a flit whose X differs from the router requests only E or W. Otherwise it requests only N or S.
- R7: A flit whose destination equals the router position is granted Local (4) if free. If Local is already taken, the flit is deflected to a link port.
- R8: The injection flit is accepted only when the number of valid link flits is below the number of link outputs present at this router. When it is refused, injBackpressure is 1 and flit 4 gets no grant.
- R9: A router on the mesh edge never grants a direction leading off the mesh. A deflected flit takes the lowest-coded free link port that exists.
- R10: deflected[i] is 1 exactly when flit i was granted a port that is not productive for it.
- R11: While reset is asserted, all grant valid bits and injBackpressure are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeDor | input | 1 | 1 = dimension-ordered routing, 0 = multidimensional |
| linkValid | input | 4 | Flit present on link N, E, S, W (bits 0..3) |
| linkDestX | input | 4*COORD_W | Destination X per link flit |
| linkDestY | input | 4*COORD_W | Destination Y per link flit |
| linkAge | input | 4*AGE_W | Age per link flit, larger is older |
| injValid | input | 1 | Local source offers a flit |
| injDestX | input | COORD_W | Destination X of the injection flit |
| injDestY | input | COORD_W | Destination Y of the injection flit |
| injAge | input | AGE_W | Age of the injection flit |
| grantValid | output | 5 | Flit i received an output (index 4 = injection) |
| grantPort | output | 15 | Granted port code per flit, 3 bits each |
| deflected | output | 5 | Flit i was sent to a non-productive port |
| injBackpressure | output | 1 | Injection flit refused this cycle |

## Verification
The bench targets contention: two flits that want the same single output at different ages and at equal ages. A design with the ranking reversed, or the tie rule flipped, gives the contested port to the wrong flit. Two flits that both want to eject show whether a second Local grant is produced rather than a deflection. A fully loaded centre router and a corner router, each offered an extra injection flit, show whether the admission limit counts the outputs actually present, and whether a deflection at the corner escapes to a port that does not exist. The same pair of flits is routed under both modes, so a design that ignores the mode, or deflects where a second productive port was free, returns different ports or deflection flags.

// File: rtl/deflect_pkg.sv
package deflect_pkg;
  localparam int NUM_LINKS = 4;
  localparam int NUM_FLITS = NUM_LINKS + 1;
  localparam int NUM_PORTS = NUM_LINKS + 1;
  localparam int PORT_BITS = 3;

  typedef enum logic [PORT_BITS-1:0] {
    DIR_N     = 3'd0,
    DIR_E     = 3'd1,
    DIR_S     = 3'd2,
    DIR_W     = 3'd3,
    DIR_LOCAL = 3'd4
  } dir_e;

  // strobes from control to datapath
  typedef struct packed {
    logic [NUM_FLITS-1:0] flitActive;
    logic                 useDor;
    logic                 injRefuse;
  } alloc_strobe_t;

  // bit order W,S,E,N: which link outputs exist at (px,py)
  function automatic logic [NUM_LINKS-1:0] linkMask(int px, int py, int mx, int my);
    linkMask = {px > 0, py > 0, px < mx - 1, py < my - 1};
  endfunction
endpackage

// File: rtl/deflect_ctrl.sv
module deflect_ctrl
  import deflect_pkg::*;
#(
  parameter int POS_X  = 3,
  parameter int POS_Y  = 3,
  parameter int MESH_X = 8,
  parameter int MESH_Y = 8
) (
  input  logic [NUM_LINKS-1:0] linkValid,
  input  logic                 injValid,
  input  logic                 modeDor,
  output alloc_strobe_t        strobe
);
  localparam logic [NUM_LINKS-1:0] LINK_EXISTS = linkMask(POS_X, POS_Y, MESH_X, MESH_Y);
  localparam logic [2:0] LINK_OUTS = 3'(int'(LINK_EXISTS[0]) + int'(LINK_EXISTS[1]) +
                                        int'(LINK_EXISTS[2]) + int'(LINK_EXISTS[3]));

  logic [2:0] linkCount;
  logic       injOk;

  always_comb begin
    linkCount = '0;
    for (int i = 0; i < NUM_LINKS; i++) linkCount = linkCount + 3'(linkValid[i]);
  end

  // admit injection only while a link output is certain to stay free
  assign injOk = injValid && (linkCount < LINK_OUTS);

  assign strobe.flitActive = {injOk, linkValid};
  assign strobe.useDor     = modeDor;
  assign strobe.injRefuse  = injValid && !injOk;
endmodule

// File: rtl/deflect_dp.sv
module deflect_dp
  import deflect_pkg::*;
#(
  parameter int POS_X   = 3,
  parameter int POS_Y   = 3,
  parameter int MESH_X  = 8,
  parameter int MESH_Y  = 8,
  parameter int COORD_W = 3,
  parameter int AGE_W   = 8
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  alloc_strobe_t                  strobe,
  input  logic [NUM_FLITS*COORD_W-1:0]   destX,
  input  logic [NUM_FLITS*COORD_W-1:0]   destY,
  input  logic [NUM_FLITS*AGE_W-1:0]     age,
  output logic [NUM_FLITS-1:0]           grantValid,
  output logic [NUM_FLITS*PORT_BITS-1:0] grantPort,
  output logic [NUM_FLITS-1:0]           deflected,
  output logic                           injBackpressure
);
  localparam logic [NUM_LINKS-1:0] LINK_EXISTS = linkMask(POS_X, POS_Y, MESH_X, MESH_Y);
  localparam logic [COORD_W-1:0]   HERE_X      = COORD_W'(POS_X);
  localparam logic [COORD_W-1:0]   HERE_Y      = COORD_W'(POS_Y);

  logic [NUM_PORTS-1:0] prodMask [NUM_FLITS];
  logic [2:0]           rank     [NUM_FLITS];

  // productive directions and age rank per flit
  for (genvar g = 0; g < NUM_FLITS; g++) begin : g_flit
    logic [COORD_W-1:0] fx, fy;
    logic [AGE_W-1:0]   myAge;
    logic               blockY;
    logic [2:0]         beatCnt;

    assign fx     = destX[g*COORD_W +: COORD_W];
    assign fy     = destY[g*COORD_W +: COORD_W];
    assign myAge  = age[g*AGE_W +: AGE_W];
    assign blockY = strobe.useDor && (fx != HERE_X);

    assign prodMask[g] = {(fx == HERE_X) && (fy == HERE_Y),
                          fx < HERE_X,
                          (fy < HERE_Y) && !blockY,
                          fx > HERE_X,
                          (fy > HERE_Y) && !blockY};

    always_comb begin
      beatCnt = '0;
      for (int j = 0; j < NUM_FLITS; j++) begin
        if (j != g && strobe.flitActive[j]) begin
          if (age[j*AGE_W +: AGE_W] > myAge ||
              (age[j*AGE_W +: AGE_W] == myAge && j < g))
            beatCnt = beatCnt + 3'd1;
        end
      end
    end
    assign rank[g] = beatCnt;
  end

  // sequential matching, oldest first
  logic [NUM_PORTS-1:0]           taken;
  logic                           found, isProd;
  logic [PORT_BITS-1:0]           pick;
  logic [NUM_FLITS-1:0]           nxtValid, nxtDefl;
  logic [NUM_FLITS*PORT_BITS-1:0] nxtPort;

  always_comb begin
    taken    = {1'b0, ~LINK_EXISTS};
    nxtValid = '0;
    nxtDefl  = '0;
    nxtPort  = '0;
    found    = 1'b0;
    isProd   = 1'b0;
    pick     = '0;
    for (int r = 0; r < NUM_FLITS; r++) begin
      for (int f = 0; f < NUM_FLITS; f++) begin
        if (strobe.flitActive[f] && rank[f] == 3'(r)) begin
          found  = 1'b0;
          isProd = 1'b0;
          pick   = '0;
          for (int p = 0; p < NUM_PORTS; p++) begin
            if (!found && prodMask[f][p] && !taken[p]) begin
              found  = 1'b1;
              isProd = 1'b1;
              pick   = PORT_BITS'(p);
            end
          end
          for (int p = 0; p < NUM_LINKS; p++) begin
            if (!found && !taken[p]) begin
              found = 1'b1;
              pick  = PORT_BITS'(p);
            end
          end
          if (found) begin
            taken[pick]                       = 1'b1;
            nxtValid[f]                       = 1'b1;
            nxtPort[f*PORT_BITS +: PORT_BITS] = pick;
            nxtDefl[f]                        = !isProd;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      grantValid      <= '0;
      grantPort       <= '0;
      deflected       <= '0;
      injBackpressure <= 1'b0;
    end else begin
      grantValid      <= nxtValid;
      grantPort       <= nxtPort;
      deflected       <= nxtDefl;
      injBackpressure <= strobe.injRefuse;
    end
  end

  for (genvar i = 0; i < NUM_LINKS; i++) begin : g_linkChk
    // R1
    link_granted_chk: assert property (@(posedge clk) disable iff (!rstN)
      strobe.flitActive[i] |=> grantValid[i]);
  end

  for (genvar i = 0; i < NUM_FLITS; i++) begin : g_portChk
    // R9
    edge_port_chk: assert property (@(posedge clk) disable iff (!rstN)
      grantValid[i] |-> (grantPort[i*PORT_BITS +: PORT_BITS] == DIR_LOCAL) ||
                        (grantPort[i*PORT_BITS +: PORT_BITS] < 3'd4 &&
                         LINK_EXISTS[grantPort[i*PORT_BITS +: 2]]));
    // R10
    defl_not_local_chk: assert property (@(posedge clk) disable iff (!rstN)
      deflected[i] |-> grantValid[i] && grantPort[i*PORT_BITS +: PORT_BITS] != DIR_LOCAL);
    for (genvar j = i + 1; j < NUM_FLITS; j++) begin : g_pair
      // R2
      distinct_port_chk: assert property (@(posedge clk) disable iff (!rstN)
        grantValid[i] && grantValid[j] |->
          grantPort[i*PORT_BITS +: PORT_BITS] != grantPort[j*PORT_BITS +: PORT_BITS]);
    end
  end

  // R8
  refuse_no_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    injBackpressure |-> !grantValid[NUM_FLITS-1]);
endmodule

// File: rtl/deflect_alloc.sv
module deflect_alloc
  import deflect_pkg::*;
#(
  parameter int POS_X   = 3,
  parameter int POS_Y   = 3,
  parameter int MESH_X  = 8,
  parameter int MESH_Y  = 8,
  parameter int COORD_W = 3,
  parameter int AGE_W   = 8
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           modeDor,
  input  logic [NUM_LINKS-1:0]           linkValid,
  input  logic [NUM_LINKS*COORD_W-1:0]   linkDestX,
  input  logic [NUM_LINKS*COORD_W-1:0]   linkDestY,
  input  logic [NUM_LINKS*AGE_W-1:0]     linkAge,
  input  logic                           injValid,
  input  logic [COORD_W-1:0]             injDestX,
  input  logic [COORD_W-1:0]             injDestY,
  input  logic [AGE_W-1:0]               injAge,
  output logic [NUM_FLITS-1:0]           grantValid,
  output logic [NUM_FLITS*PORT_BITS-1:0] grantPort,
  output logic [NUM_FLITS-1:0]           deflected,
  output logic                           injBackpressure
);
  alloc_strobe_t strobe;

  deflect_ctrl #(
    .POS_X(POS_X), .POS_Y(POS_Y), .MESH_X(MESH_X), .MESH_Y(MESH_Y)
  ) uCtrl (
    .linkValid(linkValid),
    .injValid (injValid),
    .modeDor  (modeDor),
    .strobe   (strobe)
  );

  deflect_dp #(
    .POS_X(POS_X), .POS_Y(POS_Y), .MESH_X(MESH_X), .MESH_Y(MESH_Y),
    .COORD_W(COORD_W), .AGE_W(AGE_W)
  ) uDp (
    .clk            (clk),
    .rstN           (rstN),
    .strobe         (strobe),
    .destX          ({injDestX, linkDestX}),
    .destY          ({injDestY, linkDestY}),
    .age            ({injAge, linkAge}),
    .grantValid     (grantValid),
    .grantPort      (grantPort),
    .deflected      (deflected),
    .injBackpressure(injBackpressure)
  );
endmodule

// File: tb/sim_deflect_alloc.sv
module sim_deflect_alloc;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        modeDor;
  logic [3:0]  linkValid;
  logic [11:0] linkDestX, linkDestY;
  logic [31:0] linkAge;
  logic        injValid;
  logic [2:0]  injDestX, injDestY;
  logic [7:0]  injAge;
  logic [3:0]  cornerValid;

  logic [4:0]  gv0, df0, gv1, df1;
  logic [14:0] gp0, gp1;
  logic        bp0, bp1;

  int nChecks = 0;
  int nFail   = 0;
  bit finished = 1'b0;

  assign cornerValid = linkValid & 4'b0011;

  always #(CLK_PERIOD/2) clk = ~clk;

  deflect_alloc u0 (
    .clk(clk), .rstN(rstN), .modeDor(modeDor), .linkValid(linkValid),
    .linkDestX(linkDestX), .linkDestY(linkDestY), .linkAge(linkAge),
    .injValid(injValid), .injDestX(injDestX), .injDestY(injDestY), .injAge(injAge),
    .grantValid(gv0), .grantPort(gp0), .deflected(df0), .injBackpressure(bp0)
  );

  deflect_alloc #(.POS_X(0), .POS_Y(0)) u1 (
    .clk(clk), .rstN(rstN), .modeDor(modeDor), .linkValid(cornerValid),
    .linkDestX(linkDestX), .linkDestY(linkDestY), .linkAge(linkAge),
    .injValid(injValid), .injDestX(injDestX), .injDestY(injDestY), .injAge(injAge),
    .grantValid(gv1), .grantPort(gp1), .deflected(df1), .injBackpressure(bp1)
  );

  task automatic check(string req, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clearIn();
    modeDor = 1'b0; linkValid = '0; linkDestX = '0; linkDestY = '0; linkAge = '0;
    injValid = 1'b0; injDestX = '0; injDestY = '0; injAge = '0;
  endtask

  task automatic setLink(int i, int x, int y, int a);
    linkValid[i] = 1'b1;
    linkDestX[i*3 +: 3] = 3'(x);
    linkDestY[i*3 +: 3] = 3'(y);
    linkAge[i*8 +: 8]   = 8'(a);
  endtask

  task automatic setInj(int x, int y, int a);
    injValid = 1'b1; injDestX = 3'(x); injDestY = 3'(y); injAge = 8'(a);
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic checkDistinct(string tag);
    int clash = 0;
    for (int i = 0; i < 5; i++)
      for (int j = i + 1; j < 5; j++)
        if (gv0[i] && gv0[j] && gp0[i*3 +: 3] == gp0[j*3 +: 3]) clash++;
    check("R2", tag, clash, 0);
  endtask

  task automatic testMdr();
    clearIn(); setLink(2, 5, 6, 10); step();
    check("R5", "single MDR port", int'(gp0[6 +: 3]), 0);
    check("R10", "single MDR defl", int'(df0[2]), 0);
    clearIn(); setLink(0, 5, 6, 2); setLink(1, 5, 6, 8); step();
    check("R5", "older takes N", int'(gp0[3 +: 3]), 0);
    check("R5", "younger takes E", int'(gp0[0 +: 3]), 1);
    check("R10", "second productive not deflected", int'(df0[1:0]), 0);
    checkDistinct("mdr pair");
  endtask

  task automatic testDor();
    clearIn(); modeDor = 1'b1; setLink(2, 5, 6, 10); step();
    check("R6", "X first", int'(gp0[6 +: 3]), 1);
    clearIn(); modeDor = 1'b1; setLink(2, 3, 6, 10); step();
    check("R6", "Y after X", int'(gp0[6 +: 3]), 0);
    clearIn(); modeDor = 1'b1; setLink(0, 5, 6, 2); setLink(1, 5, 6, 8); step();
    check("R6", "older gets E", int'(gp0[3 +: 3]), 1);
    check("R6", "younger deflected to N", int'(gp0[0 +: 3]), 0);
    check("R10", "dor defl flags", int'(df0[1:0]), 1);
  endtask

  task automatic testAge();
    clearIn(); setLink(0, 5, 3, 5); setLink(1, 5, 3, 9); step();
    check("R3", "older wins E", int'(gp0[3 +: 3]), 1);
    check("R3", "younger deflected N", int'(gp0[0 +: 3]), 0);
    check("R3", "defl flags", int'(df0[1:0]), 1);
    check("R1", "both granted", int'(gv0[1:0]), 3);
  endtask

  task automatic testTie();
    clearIn(); setLink(0, 5, 3, 7); setLink(1, 5, 3, 7); step();
    check("R4", "lower index wins E", int'(gp0[0 +: 3]), 1);
    check("R4", "higher index deflected N", int'(gp0[3 +: 3]), 0);
    check("R4", "defl flags", int'(df0[1:0]), 2);
  endtask

  task automatic testEject();
    clearIn(); setLink(0, 3, 3, 4); setLink(3, 3, 3, 6); step();
    check("R7", "older ejects", int'(gp0[9 +: 3]), 4);
    check("R7", "second eject deflected", int'(gp0[0 +: 3]), 0);
    check("R7", "defl flags", int'(df0[3:0]), 1);
    checkDistinct("eject");
  endtask

  task automatic testRefuse();
    clearIn();
    setLink(0, 3, 0, 1); setLink(1, 3, 0, 2); setLink(2, 3, 0, 3); setLink(3, 3, 0, 4);
    setInj(6, 3, 50); step();
    check("R1", "all links granted", int'(gv0[3:0]), 15);
    check("R8", "backpressure", int'(bp0), 1);
    check("R8", "injection not granted", int'(gv0[4]), 0);
    check("R3", "port l3", int'(gp0[9 +: 3]), 2);
    check("R3", "port l2", int'(gp0[6 +: 3]), 0);
    check("R3", "port l1", int'(gp0[3 +: 3]), 1);
    check("R3", "port l0", int'(gp0[0 +: 3]), 3);
    check("R10", "defl flags full", int'(df0[3:0]), 7);
    checkDistinct("full");
  endtask

  task automatic testAccept();
    clearIn();
    setLink(0, 3, 0, 1); setLink(1, 3, 0, 2); setLink(2, 3, 0, 3); setInj(6, 3, 0); step();
    check("R8", "no backpressure", int'(bp0), 0);
    check("R8", "injection granted", int'(gv0[4]), 1);
    check("R9", "injection deflected W", int'(gp0[12 +: 3]), 3);
    check("R10", "injection defl flag", int'(df0[4]), 1);
    checkDistinct("accept");
  endtask

  task automatic testCorner();
    clearIn(); setLink(0, 0, 5, 3); setLink(1, 0, 5, 8); setInj(2, 0, 1); step();
    check("R8", "corner backpressure", int'(bp1), 1);
    check("R8", "corner inj no grant", int'(gv1[4]), 0);
    check("R9", "corner older N", int'(gp1[3 +: 3]), 0);
    check("R9", "corner deflect to E", int'(gp1[0 +: 3]), 1);
    check("R10", "corner defl flags", int'(df1[1:0]), 1);
    clearIn(); setLink(0, 0, 5, 2); setInj(3, 0, 9); step();
    check("R8", "corner inj accepted", int'(gv1[4]), 1);
    check("R8", "corner no backpressure", int'(bp1), 0);
    check("R3", "older inj takes E", int'(gp1[12 +: 3]), 1);
    check("R5", "link takes N", int'(gp1[0 +: 3]), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog R1: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    clearIn();
    setLink(0, 5, 5, 1);
    setInj(1, 1, 1);
    repeat (3) step();
    check("R11", "reset grants", int'(gv0), 0);
    check("R11", "reset backpressure", int'(bp0), 0);
    check("R11", "reset corner grants", int'(gv1), 0);
    rstN = 1'b1;
    clearIn();
    step();
    testMdr();
    testDor();
    testAge();
    testTie();
    testEject();
    testRefuse();
    testAccept();
    testCorner();
    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule